// File: doc/BRIEF.md
# Cascaded Biquad Filter Coprocessor

This block filters one sample at a time through a chain of up to 21 second-order IIR sections. All sections share a single signed multiply-accumulate unit, so each section takes five cycles, one for each of its taps. The host first loads the 32-bit coefficients for every section through a simple write port. It then issues commands through a valid/ready handshake. A command carries a 56-bit input sample, the number of sections to run, an output-width code and a destination address. Each section keeps its own two-deep input and output history. That history carries over from one command to the next, so a stream of commands filters a stream of samples.

When the last active section finishes, the block reduces the 56-bit result to 24, 32 or 48 bits by keeping its upper bits. It sign-extends that value into a 64-bit word and holds a memory write request until the memory side accepts it. A separate clear command wipes the history of every section without producing a write. The block is busy from the moment it accepts a filtering command until its write has been accepted, and it takes no new command during that time.

Top module: `iirc_top`

## Requirements
- R1: During and right after reset, cmd_ready is 1, busy is 0 and mem_valid is 0.
- R2: Section s reads its coefficients at coef_addr 5·s+0 through 5·s+4, in the order b0, b1, b2, a1, a2. These are signed values with 30 fraction bits. The section computes y = (b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2), shifted arithmetically right by 30. Here x1 and x2 are the section's two previous inputs and y1 and y2 are its two previous outputs.
- R3: Each section's output is saturated to the signed 56-bit range: results above 2^55−1 become 2^55−1, and results below −2^55 become −2^55.
- R4: The output of section k is the input of section k+1. A command runs sections 0 to cmd_nsec−1. A cmd_nsec of 0 passes the sample through unchanged, and a value above 21 is treated as 21.
- R5: A section updates its history only when it completes a computation. History persists across commands. Sections beyond cmd_nsec keep their history unchanged.
- R6: A command with cmd_clear=1 zeroes the history of all sections. It produces no memory write and does not raise busy.
- R7: The write word is formed by cmd_width. Code 0 gives result bits 55:32, code 1 gives bits 55:24, and codes 2 and 3 give bits 55:8. In every case the value is sign-extended to 64 bits.
- R8: The write request presents cmd_addr and the word on mem_addr and mem_wdata, and holds both stable until mem_ready is seen.
- R9: busy rises in the cycle after a filtering command is accepted. cmd_ready is low while busy is high, and busy drops in the cycle after the write handshake.
- R10: mem_valid rises 5·n cycles after the accepting clock edge, where n is the effective section count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient index, 5·section + tap |
| coef_wdata | input | 32 | Coefficient value, signed with 30 fraction bits |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_clear | input | 1 | Command clears all history instead of filtering |
| cmd_sample | input | 56 | Signed input sample |
| cmd_nsec | input | 5 | Number of sections to run |
| cmd_width | input | 2 | Output width code |
| cmd_addr | input | 32 | Destination address of the result |
| busy | output | 1 | Filtering command in progress |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Write accepted |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 64 | Sign-extended truncated result |

## Verification
The per-section history is the only state the ports cannot observe directly. A wrong history value, or an update of the wrong section, shows up in the data word of the very next command that runs through that section. If the fault is in a section that a short command skips, it appears in the first later command long enough to reach that section. The bench therefore alternates short and long chains and places clears between them, so that lost, stale or misrouted history turns into a data mismatch within one or two commands. A tap or sequencing fault changes the cycle in which mem_valid rises, which the bench catches on the same command.

// File: rtl/iirc_pkg.sv
package iirc_pkg;
    localparam int DATA_W = 56;
    localparam int COEF_W = 32;
    localparam int ACC_W  = 96;
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int FRAC_W = 30;
    localparam int TAPS   = 5;
    localparam int WORD_W = 64;
    localparam int NARROW_W = 24;
    localparam int MID_W    = 32;
    localparam int WIDE_W   = 48;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [WORD_W-1:0]        word_t;

    typedef enum logic [1:0] {
        OUT_24  = 2'd0,
        OUT_32  = 2'd1,
        OUT_48  = 2'd2,
        OUT_48X = 2'd3
    } out_w_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_STORE = 2'd2
    } phase_e;

    // two-deep history of one section
    typedef struct packed {
        sample_t x1;
        sample_t x2;
        sample_t y1;
        sample_t y2;
    } hist_t;

    // drop fraction bits, clamp to the sample range
    function automatic sample_t requant(input acc_t a);
        acc_t s;
        acc_t hi;
        acc_t lo;
        sample_t r;
        s  = a >>> FRAC_W;
        hi = acc_t'({1'b0, {(DATA_W-1){1'b1}}});
        lo = ~hi;
        if (s > hi)      r = sample_t'(hi);
        else if (s < lo) r = sample_t'(lo);
        else             r = sample_t'(s);
        return r;
    endfunction

    // keep the upper bits, sign-extend to the write word
    function automatic word_t shape_out(input sample_t v, input logic [1:0] w);
        word_t r;
        case (out_w_e'(w))
            OUT_24:  r = {{(WORD_W-NARROW_W){v[DATA_W-1]}}, v[DATA_W-1 -: NARROW_W]};
            OUT_32:  r = {{(WORD_W-MID_W){v[DATA_W-1]}}, v[DATA_W-1 -: MID_W]};
            default: r = {{(WORD_W-WIDE_W){v[DATA_W-1]}}, v[DATA_W-1 -: WIDE_W]};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/iirc_coef_bank.sv
module iirc_coef_bank import iirc_pkg::*; #(
    parameter int N_ENT = 105,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  coef_t         wdata,
    input  logic [IW-1:0] raddr,
    output coef_t         rdata
);
    coef_t mem [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) mem[i] <= '0;
        end else if (we && (int'(waddr) < N_ENT)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < N_ENT) ? mem[raddr] : '0;
endmodule

// File: rtl/iirc_hist_bank.sv
module iirc_hist_bank import iirc_pkg::*; #(
    parameter int N_SEC = 21,
    parameter int SW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  sample_t       xin,
    input  sample_t       yin,
    output hist_t         rd
);
    hist_t mem [N_SEC];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < N_SEC; i++) mem[i] <= '0;
        end else if (we && (int'(sel) < N_SEC)) begin
            mem[sel] <= '{x1: xin, x2: mem[sel].x1, y1: yin, y2: mem[sel].y1};
        end
    end

    assign rd = (int'(sel) < N_SEC) ? mem[sel] : '0;
endmodule

// File: rtl/iirc_mac.sv
module iirc_mac import iirc_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    clr,
    input  logic    sub,
    input  sample_t opa,
    input  coef_t   opb,
    output acc_t    acc_q,
    output acc_t    acc_sum
);
    logic signed [PROD_W-1:0] prod;
    acc_t term;

    always_comb begin
        prod    = PROD_W'(opa) * PROD_W'(opb);
        term    = ACC_W'(prod);
        acc_sum = sub ? (acc_q - term) : (acc_q + term);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  acc_q <= '0;
        else if (en)     acc_q <= acc_sum;
    end
endmodule

// File: rtl/iirc_top.sv
module iirc_top import iirc_pkg::*; #(
    parameter  int N_SEC  = 21,
    parameter  int ADDR_W = 32,
    localparam int N_COEF = N_SEC * TAPS,
    localparam int CIW    = $clog2(N_COEF),
    localparam int SW     = $clog2(N_SEC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_we,
    input  logic [CIW-1:0]    coef_addr,
    input  logic [COEF_W-1:0] coef_wdata,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_clear,
    input  logic [DATA_W-1:0] cmd_sample,
    input  logic [SW-1:0]     cmd_nsec,
    input  logic [1:0]        cmd_width,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    localparam logic [2:0] TAP_LAST = 3'(TAPS - 1);

    phase_e            phase;
    logic [SW-1:0]     sec, last_sec, n_eff;
    logic [2:0]        tap;
    sample_t           xcur, result, opnd, y_sec;
    logic [1:0]        width_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CIW-1:0]    craddr;
    coef_t             cval;
    hist_t             hist;
    acc_t              acc_q, acc_sum;
    logic              sec_done, clr_hist, run;

    assign run      = (phase == S_RUN);
    assign sec_done = run && (tap == TAP_LAST);
    assign clr_hist = (phase == S_IDLE) && cmd_valid && cmd_clear;
    assign n_eff    = (cmd_nsec > SW'(N_SEC)) ? SW'(N_SEC) : cmd_nsec;
    assign craddr   = CIW'(int'(sec) * TAPS + int'(tap));
    assign y_sec    = requant(acc_sum);

    always_comb begin
        case (tap)
            3'd0:    opnd = xcur;
            3'd1:    opnd = hist.x1;
            3'd2:    opnd = hist.x2;
            3'd3:    opnd = hist.y1;
            default: opnd = hist.y2;
        endcase
    end

    iirc_coef_bank #(.N_ENT(N_COEF), .IW(CIW)) u_coef (
        .clk(clk), .rst(rst), .we(coef_we), .waddr(coef_addr),
        .wdata(coef_t'(coef_wdata)), .raddr(craddr), .rdata(cval)
    );

    iirc_hist_bank #(.N_SEC(N_SEC), .SW(SW)) u_hist (
        .clk(clk), .rst(rst), .clr(clr_hist), .we(sec_done), .sel(sec),
        .xin(xcur), .yin(y_sec), .rd(hist)
    );

    iirc_mac u_mac (
        .clk(clk), .rst(rst), .en(run), .clr(sec_done), .sub(tap >= 3'd3),
        .opa(opnd), .opb(cval), .acc_q(acc_q), .acc_sum(acc_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= S_IDLE;
            sec      <= '0;
            last_sec <= '0;
            tap      <= '0;
            xcur     <= '0;
            result   <= '0;
            width_q  <= '0;
            addr_q   <= '0;
        end else begin
            case (phase)
                S_IDLE: if (cmd_valid && !cmd_clear) begin
                    xcur    <= sample_t'(cmd_sample);
                    sec     <= '0;
                    tap     <= '0;
                    width_q <= cmd_width;
                    addr_q  <= cmd_addr;
                    if (n_eff == '0) begin
                        result <= sample_t'(cmd_sample);
                        phase  <= S_STORE;
                    end else begin
                        last_sec <= n_eff - 1'b1;
                        phase    <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (tap == TAP_LAST) begin
                        tap  <= '0;
                        xcur <= y_sec;
                        if (sec == last_sec) begin
                            result <= y_sec;
                            phase  <= S_STORE;
                        end else begin
                            sec <= sec + 1'b1;
                        end
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                S_STORE: if (mem_ready) phase <= S_IDLE;
                default: phase <= S_IDLE;
            endcase
        end
    end

    assign cmd_ready = (phase == S_IDLE);
    assign busy      = (phase != S_IDLE);
    assign mem_valid = (phase == S_STORE);
    assign mem_addr  = addr_q;
    assign mem_wdata = shape_out(result, width_q);
endmodule

// File: rtl/iirc_chk.sv
module iirc_chk import iirc_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_clear,
    input logic              busy,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata
);
    a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !cmd_clear) |=> busy);

    a_r9_release_after_write: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> !busy);

    a_r9_write_inside_busy: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy);

    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

    a_r7_sign_extended: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_wdata[WORD_W-1:WIDE_W-1] == {(WORD_W-WIDE_W+1){mem_wdata[WIDE_W-1]}}));

    a_r6_clear_silent: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_clear) |=> (!busy && !mem_valid));
endmodule

bind iirc_top iirc_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_clear(cmd_clear), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/iirc_top_tb.sv
module iirc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        coef_we = 1'b0;
    logic [6:0]  coef_addr = '0;
    logic [31:0] coef_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_clear = 1'b0;
    logic [55:0] cmd_sample = '0;
    logic [4:0]  cmd_nsec = '0;
    logic [1:0]  cmd_width = '0;
    logic [31:0] cmd_addr = '0;
    logic        busy;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;

    always #5 clk = ~clk;

    iirc_top u_dut (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_clear(cmd_clear), .cmd_sample(cmd_sample), .cmd_nsec(cmd_nsec),
        .cmd_width(cmd_width), .cmd_addr(cmd_addr), .busy(busy),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int acc_cyc = 0;
    bit stall = 1'b0;
    bit vprev = 1'b0;
    bit hs_prev = 1'b0;

    typedef struct {
        logic [31:0] a;
        logic [63:0] d;
        int          lat;
        string       tag;
    } exp_t;
    exp_t q[$];

    // independent model state
    logic signed [31:0] mc  [105];
    logic signed [55:0] mx1 [21];
    logic signed [55:0] mx2 [21];
    logic signed [55:0] my1 [21];
    logic signed [55:0] my2 [21];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic signed [95:0] mul96(input logic signed [55:0] a, input logic signed [31:0] b);
        logic signed [95:0] aa;
        logic signed [95:0] bb;
        aa = a;
        bb = b;
        return aa * bb;
    endfunction

    function automatic logic signed [55:0] mdl_sec(input int s, input logic signed [55:0] x);
        logic signed [95:0] acc;
        logic signed [95:0] t;
        logic signed [95:0] hi;
        logic signed [95:0] lo;
        logic signed [55:0] y;
        acc = mul96(x, mc[s*5]) + mul96(mx1[s], mc[s*5+1]) + mul96(mx2[s], mc[s*5+2])
            - mul96(my1[s], mc[s*5+3]) - mul96(my2[s], mc[s*5+4]);
        t  = acc >>> 30;
        hi = (96'sd1 <<< 55) - 96'sd1;
        lo = -(96'sd1 <<< 55);
        if (t > hi)      y = hi[55:0];
        else if (t < lo) y = lo[55:0];
        else             y = t[55:0];
        mx2[s] = mx1[s];
        mx1[s] = x;
        my2[s] = my1[s];
        my1[s] = y;
        return y;
    endfunction

    function automatic logic [63:0] mdl_word(input logic signed [55:0] y, input int w);
        logic signed [63:0] e;
        if (w == 0)      e = $signed(y[55:32]);
        else if (w == 1) e = $signed(y[55:24]);
        else             e = $signed(y[55:8]);
        return e;
    endfunction

    task automatic wcoef(input int idx, input logic signed [31:0] v);
        @(negedge clk);
        coef_we = 1'b1;
        coef_addr = 7'(idx);
        coef_wdata = v;
        mc[idx] = v;
        @(posedge clk);
        #1 coef_we = 1'b0;
    endtask

    task automatic send(input bit clr, input logic signed [55:0] x, input int n,
                        input int w, input logic [31:0] a, input string tag);
        logic signed [55:0] y;
        int ne;
        exp_t it;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_clear  = clr;
        cmd_sample = x;
        cmd_nsec   = 5'(n);
        cmd_width  = 2'(w);
        cmd_addr   = a;
        if (clr) begin
            for (int s = 0; s < 21; s++) begin
                mx1[s] = '0; mx2[s] = '0; my1[s] = '0; my2[s] = '0;
            end
        end else begin
            ne = (n > 21) ? 21 : n;
            y = x;
            for (int s = 0; s < ne; s++) y = mdl_sec(s, y);
            it.a = a;
            it.d = mdl_word(y, w);
            it.lat = 5 * ne;
            it.tag = tag;
            q.push_back(it);
        end
        acc_cyc = cyc + 1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        cmd_clear = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            mem_ready = stall ? ((cyc % 3) == 0) : 1'b1;
            if (hs_prev) chk(!busy, "R9 busy low after write", 64'(busy), 64'd0);
            hs_prev = 1'b0;
            if (mem_valid && !vprev) begin
                if (q.size() == 0) chk(1'b0, "R6 unexpected write", 64'(mem_addr), 64'd0);
                else chk((cyc - acc_cyc) == q[0].lat, "R10 latency",
                         64'(cyc - acc_cyc), 64'(q[0].lat));
            end
            if (mem_valid && mem_ready && q.size() != 0) begin
                exp_t it;
                it = q.pop_front();
                chk(mem_addr == it.a, "R8 address", 64'(mem_addr), 64'(it.a));
                chk(mem_wdata == it.d, it.tag, mem_wdata, it.d);
                hs_prev = 1'b1;
            end
            vprev = mem_valid;
        end
    end

    initial begin
        logic signed [55:0] big;
        logic signed [55:0] neg;
        logic signed [55:0] smax;
        logic signed [55:0] smin;
        big  = 56'sd1 <<< 50;
        neg  = -(56'sd1 <<< 49) - 56'sd12345;
        smax = (56'sd1 <<< 55) - 56'sd1;
        smin = -(56'sd1 <<< 55);
        for (int i = 0; i < 105; i++) mc[i] = '0;
        for (int s = 0; s < 21; s++) begin
            mx1[s] = '0; mx2[s] = '0; my1[s] = '0; my2[s] = '0;
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 ready in reset", 64'(cmd_ready), 64'd1);
        chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
        chk(mem_valid == 1'b0, "R1 valid in reset", 64'(mem_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && busy == 1'b0 && mem_valid == 1'b0, "R1 idle after reset",
            64'({cmd_ready, busy, mem_valid}), 64'b100);

        // unity pass sections, then shaped first two and last
        for (int s = 0; s < 21; s++) wcoef(s*5, 32'sd1 <<< 30);
        wcoef(0, 32'sd1 <<< 29);
        wcoef(1, 32'sd1 <<< 28);
        wcoef(2, -(32'sd1 <<< 27));
        wcoef(3, 32'sd1 <<< 29);
        wcoef(4, -(32'sd1 <<< 27));
        wcoef(5, 32'sd3 <<< 28);
        wcoef(7, 32'sd1 <<< 28);
        wcoef(8, -(32'sd1 <<< 28));
        wcoef(9, 32'sd1 <<< 26);
        wcoef(100, 32'sd3 <<< 29);

        send(1'b0, big, 1, 2, 32'h1000, "R2 one section");
        @(negedge clk);
        chk(busy == 1'b1 && cmd_ready == 1'b0, "R9 busy while running",
            64'({busy, cmd_ready}), 64'b10);
        send(1'b0, neg, 2, 0, 32'h1008, "R7 width 24");
        send(1'b0, big, 2, 1, 32'h1010, "R7 width 32");
        send(1'b0, neg, 2, 3, 32'h1018, "R7 width code 3");
        send(1'b0, big, 1, 2, 32'h1020, "R5 short chain");
        send(1'b0, neg, 2, 2, 32'h1028, "R5 history kept beyond chain");
        send(1'b1, '0, 0, 0, 32'h0, "clear");
        @(negedge clk);
        chk(busy == 1'b0 && mem_valid == 1'b0, "R6 clear silent",
            64'({busy, mem_valid}), 64'b00);
        send(1'b0, big, 2, 2, 32'h1030, "R6 history zero after clear");
        send(1'b0, neg, 0, 1, 32'h1038, "R4 zero sections bypass");
        send(1'b0, big, 21, 2, 32'h1040, "R4 full chain");
        send(1'b0, big, 29, 2, 32'h1048, "R4 clamp to 21");
        stall = 1'b1;
        send(1'b0, neg, 2, 0, 32'h1050, "R8 stalled write");
        send(1'b0, big, 0, 2, 32'h1058, "R8 stalled bypass");
        while (q.size() != 0 || busy) @(negedge clk);
        stall = 1'b0;
        send(1'b1, '0, 0, 0, 32'h0, "clear");
        wcoef(0, 32'sh7FFFFFFF);
        for (int i = 1; i < 5; i++) wcoef(i, 32'sd0);
        send(1'b0, smax, 1, 2, 32'h1060, "R3 saturate high");
        send(1'b0, smin, 1, 2, 32'h1068, "R3 saturate low");
        send(1'b0, 56'sd1 <<< 40, 1, 2, 32'h1070, "R3 no clamp in range");
        while (q.size() != 0 || busy) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule